// File: doc/BRIEF.md
# Multi-Mode Period Timer

This block is a 16-bit up-counter with a period compare register and a sticky event flag. It can count one of three things. The first is an internal tick qualifier, which gives timer mode. The second is the rising edges of an external clock after a two-flop synchronizer, which gives synchronous counting. The third is the raw rising edges of that external clock, which gives asynchronous counting. A fixed-ratio prescaler sits in front of the counter. When the counter reaches the period value, it returns to zero on the next counted pulse and keeps running.

In timer mode, a gate input can restrict counting to the time the gate is high. In that case the event flag marks the falling edge of the gate instead of a period match. An idle input can stop the counter when the stop-in-idle control is set. Software reloads the count through a write port, sets the period through a second write port, and clears the flag with a pulse. Everything runs in the system clock domain. The external clock is oversampled, so it must stay high and low for at least one system clock each.

Top module: `ptmr_top`

## Requirements
- R1: After a synchronous active-low reset, `cnt_q` is 0, `flag_q` is 0 and the period register holds 0xFFFF.
- R2: Each prescaled pulse adds one to the count. A pulse that arrives while the count equals the period loads 0, so a period of P gives P+1 pulses per cycle. A count above the period keeps rising and wraps from 0xFFFF to 0 without raising the flag.
- R3: With `ctl_ext`=0, the source pulse is `tick_en`, sampled on the same clock edge at which the count changes.
- R4: With `ctl_ext`=1 and `ctl_sync`=1, a rising edge of `ext_clk` is first seen high at edge k and is counted at edge k+2.
- R5: With `ctl_ext`=1 and `ctl_sync`=0, a rising edge of `ext_clk` first seen high at edge k is counted at edge k itself.
- R6: `ctl_ps` codes 00, 01, 10 and 11 pass every 1st, 8th, 64th and 256th source pulse to the counter.
- R7: The prescaler's internal count returns to zero on any cycle with `cnt_we`=1 or `ctl_on`=0.
- R8: While `ctl_sidl`=1 and `idle`=1, no source pulse is counted and the count holds. With `ctl_sidl`=0, `idle` has no effect.
- R9: With `ctl_gate`=1 and `ctl_ext`=0, ticks are counted only while the synchronized gate is high. A gate level first seen at edge k governs ticks from edge k+2 onward. With `ctl_ext`=1, `ctl_gate` is ignored.
- R10: In gated mode with `ctl_on`=1, a falling edge of `ext_gate` first seen low at edge k sets the flag at edge k+2. A period match does not set the flag in gated mode.
- R11: `flag_q` stays 1 until a cycle with `flag_clr`=1. If a set event and a clear fall in the same cycle, the set wins.
- R12: With `ctl_on`=0, the count holds its value and no pulse is counted.
- R13: `cnt_we` loads `cnt_wdata` and overrides any increment in that cycle. `per_we` loads `per_wdata`, and a match in that same cycle compares against the old period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Internal tick qualifier for timer mode |
| ext_clk | input | 1 | External count clock, oversampled |
| ext_gate | input | 1 | Gate input for gated accumulation |
| idle | input | 1 | Idle-state indication |
| ctl_on | input | 1 | Counter enable |
| ctl_sync | input | 1 | 1 = synchronize the external clock |
| ctl_ext | input | 1 | 1 = external clock source, 0 = internal tick |
| ctl_gate | input | 1 | Gated accumulation enable |
| ctl_ps | input | 2 | Prescaler select: 00 /1, 01 /8, 10 /64, 11 /256 |
| ctl_sidl | input | 1 | Stop counting while idle |
| per_we | input | 1 | Period register write strobe |
| per_wdata | input | 16 | Period write data |
| cnt_we | input | 1 | Count register write strobe |
| cnt_wdata | input | 16 | Count write data |
| cnt_q | output | 16 | Current count |
| flag_clr | input | 1 | Clear pulse for the event flag |
| flag_q | output | 1 | Sticky event flag |

## Verification
Each result has a fixed latency from its stimulus:
- Timer ticks, asynchronous edges and register writes show on `cnt_q` right after the edge that samples them.
- Synchronized external edges are counted two edges after they are first seen.
- Gate levels take effect two edges after they are first seen, and a gate fall sets the flag two edges after it is first seen.

The bench drives inputs only at falling edges. At each rising edge, a behavioural model in the bench applies the same latencies using sample histories. The bench then compares `cnt_q` and `flag_q` against the model at the next falling edge, so every compare lands after one settled update. Separate phases exercise each source, each prescaler code, idle, gating, wraps and the flag clear/set race.

// File: rtl/ptmr_pkg.sv
// Package: shared types and helpers for the period timer.
// Assumes the prescaler counter is at least 8 bits wide.
package ptmr_pkg;

    typedef enum logic [1:0] {
        PS_DIV1   = 2'b00,
        PS_DIV8   = 2'b01,
        PS_DIV64  = 2'b10,
        PS_DIV256 = 2'b11
    } ps_sel_e;

    // Last prescaler count value before an output pulse, per select code.
    function automatic logic [7:0] ps_last(input ps_sel_e sel);
        case (sel)
            PS_DIV1:   ps_last = 8'd0;
            PS_DIV8:   ps_last = 8'd7;
            PS_DIV64:  ps_last = 8'd63;
            default:   ps_last = 8'd255;
        endcase
    endfunction

endpackage

// File: rtl/ptmr_src.sv
// Module: ptmr_src
// Picks the source pulse for the timer: the internal tick (optionally gated
// by the synchronized gate), a synchronized external edge, or a raw external
// edge. Also detects gate falling edges. Assumes ext_clk and ext_gate are
// each held for at least one clk period per level.
module ptmr_src #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic ext_clk,
    input  logic ext_gate,
    input  logic use_ext,
    input  logic use_sync,
    input  logic gate_en,
    output logic src_pulse,
    output logic gated_mode,
    output logic gate_fall
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] ext_sh;
    logic [SH_W-1:0] gate_sh;
    logic            ext_sync_lvl;
    logic            ext_sync_prev;
    logic            gate_lvl;
    logic            gate_prev;
    logic            sync_edge;
    logic            raw_edge;

    // Sample history of the external clock: synchronizer plus edge stage.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_sh <= '0;
        else        ext_sh <= {ext_sh[SH_W-2:0], ext_clk};
    end

    // Sample history of the gate: synchronizer plus edge stage.
    always_ff @(posedge clk) begin
        if (!rst_n) gate_sh <= '0;
        else        gate_sh <= {gate_sh[SH_W-2:0], ext_gate};
    end

    assign ext_sync_lvl  = ext_sh[SYNC_STAGES-1];
    assign ext_sync_prev = ext_sh[SYNC_STAGES];
    assign gate_lvl      = gate_sh[SYNC_STAGES-1];
    assign gate_prev     = gate_sh[SYNC_STAGES];

    assign sync_edge  = ext_sync_lvl & ~ext_sync_prev;
    // Raw edge: current pin level against a single previous sample.
    assign raw_edge   = ext_clk & ~ext_sh[0];
    assign gated_mode = gate_en & ~use_ext;
    assign gate_fall  = gated_mode & gate_prev & ~gate_lvl;

    // Selects the pulse that feeds the prescaler.
    always_comb begin
        if (!use_ext)      src_pulse = tick_en & (~gate_en | gate_lvl);
        else if (use_sync) src_pulse = sync_edge;
        else               src_pulse = raw_edge;
    end

    // R9: the gate fall event only exists with the internal source selected.
    assert_fall_internal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        gate_fall |-> (gate_en && !use_ext));

endmodule

// File: rtl/ptmr_prescale.sv
// Module: ptmr_prescale
// Divides a pulse stream by 1, 8, 64 or 256. Its count clears on request.
// Assumes the pulse input is already qualified by enable and idle.
module ptmr_prescale
    import ptmr_pkg::*;
#(
    parameter int PRE_W = 8
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    clear,
    input  logic    pulse_in,
    input  ps_sel_e sel,
    output logic    pulse_out
);
    logic [PRE_W-1:0] pcnt;
    logic [PRE_W-1:0] last;

    assign last      = PRE_W'(ps_last(sel));
    assign pulse_out = pulse_in & (pcnt >= last);

    // Counts input pulses and restarts after the last one of a group.
    always_ff @(posedge clk) begin
        if (!rst_n)        pcnt <= '0;
        else if (clear)    pcnt <= '0;
        else if (pulse_in) pcnt <= (pcnt >= last) ? '0 : pcnt + 1'b1;
    end

    // R7: a clear request leaves the prescaler at zero.
    assert_pre_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (pcnt == '0));

endmodule

// File: rtl/ptmr_count.sv
// Module: ptmr_count
// Holds the count and period registers. Increments, wraps on a period
// match, and accepts writes. Assumes inc is a single-cycle pulse.
module ptmr_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             per_we,
    input  logic [CNT_W-1:0] per_wdata,
    output logic [CNT_W-1:0] cnt_q,
    output logic             match
);
    logic [CNT_W-1:0] per_q;

    assign match = inc & (cnt_q == per_q);

    // Period register: software write, all ones after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      per_q <= '1;
        else if (per_we) per_q <= per_wdata;
    end

    // Count register: a write wins, then wrap on match, else step by one.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (wr_en) cnt_q <= wr_data;
        else if (inc)   cnt_q <= match ? '0 : cnt_q + 1'b1;
    end

    // R2: without a write the count only holds, steps by one, or wraps to 0.
    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1 || cnt_q == '0));

    // R2: a match without a write returns the count to zero.
    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !wr_en) |=> (cnt_q == '0));

    // R13: a write takes effect on the next cycle.
    assert_write_R13: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cnt_q == $past(wr_data)));

endmodule

// File: rtl/ptmr_top.sv
// Module: ptmr_top
// Multi-mode period timer. It wires source selection, prescaler and counter,
// and owns the sticky event flag. Assumes all inputs are synchronous to clk
// except ext_clk and ext_gate, which are oversampled.
module ptmr_top
    import ptmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int PRE_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             ext_clk,
    input  logic             ext_gate,
    input  logic             idle,
    input  logic             ctl_on,
    input  logic             ctl_sync,
    input  logic             ctl_ext,
    input  logic             ctl_gate,
    input  logic [1:0]       ctl_ps,
    input  logic             ctl_sidl,
    input  logic             per_we,
    input  logic [CNT_W-1:0] per_wdata,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] cnt_q,
    input  logic             flag_clr,
    output logic             flag_q
);
    logic src_pulse;
    logic gated_mode;
    logic gate_fall;
    logic halt;
    logic pre_in;
    logic pre_clr;
    logic inc;
    logic match;
    logic flag_set;

    assign halt    = ctl_sidl & idle;
    assign pre_in  = ctl_on & ~halt & src_pulse;
    assign pre_clr = cnt_we | ~ctl_on;

    ptmr_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .ext_clk    (ext_clk),
        .ext_gate   (ext_gate),
        .use_ext    (ctl_ext),
        .use_sync   (ctl_sync),
        .gate_en    (ctl_gate),
        .src_pulse  (src_pulse),
        .gated_mode (gated_mode),
        .gate_fall  (gate_fall)
    );

    ptmr_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (pre_clr),
        .pulse_in  (pre_in),
        .sel       (ps_sel_e'(ctl_ps)),
        .pulse_out (inc)
    );

    ptmr_count #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc       (inc),
        .wr_en     (cnt_we),
        .wr_data   (cnt_wdata),
        .per_we    (per_we),
        .per_wdata (per_wdata),
        .cnt_q     (cnt_q),
        .match     (match)
    );

    assign flag_set = (match & ~gated_mode) | (gate_fall & ctl_on);

    // Sticky event flag: a set event beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (flag_set) flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    // R11: the flag holds until a clear arrives.
    assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr) |=> flag_q);

    // R11: a set event always shows on the flag the next cycle.
    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flag_set |=> flag_q);

    // R8: stop-in-idle freezes the count.
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_sidl && idle && !cnt_we) |=> $stable(cnt_q));

    // R12: a disabled timer keeps its count.
    assert_off_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_on && !cnt_we) |=> $stable(cnt_q));

endmodule

// File: tb/ptmr_top_tb.sv
`timescale 1ns/1ps
module ptmr_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0, ext_clk = 1'b0, ext_gate = 1'b0, idle = 1'b0;
    logic        ctl_on = 1'b0, ctl_sync = 1'b0, ctl_ext = 1'b0, ctl_gate = 1'b0, ctl_sidl = 1'b0;
    logic [1:0]  ctl_ps = 2'b00;
    logic        per_we = 1'b0, cnt_we = 1'b0, flag_clr = 1'b0;
    logic [15:0] per_wdata = '0, cnt_wdata = '0;
    logic [15:0] cnt_q;
    logic        flag_q;

    int    errors = 0, checks = 0, cycles = 0;
    string cur_req = "R1";
    bit    comparing = 1'b0;

    // behavioural reference state
    int m_cnt, m_per, m_pre;
    bit m_flag;
    bit eh [3];
    bit gh [3];

    always #2 clk = ~clk;

    ptmr_top u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ext_clk(ext_clk),
        .ext_gate(ext_gate), .idle(idle), .ctl_on(ctl_on), .ctl_sync(ctl_sync),
        .ctl_ext(ctl_ext), .ctl_gate(ctl_gate), .ctl_ps(ctl_ps), .ctl_sidl(ctl_sidl),
        .per_we(per_we), .per_wdata(per_wdata), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .cnt_q(cnt_q), .flag_clr(flag_clr), .flag_q(flag_q)
    );

    // Reference model: advances on each rising edge from the stable inputs.
    always @(posedge clk) begin
        bit pulse, gmode, fall, adv, stp, hit;
        int lim;
        if (!rst_n) begin
            m_cnt = 0; m_per = 16'hFFFF; m_pre = 0; m_flag = 0;
            foreach (eh[i]) begin eh[i] = 0; gh[i] = 0; end
        end else begin
            if (!ctl_ext)      pulse = tick_en && (!ctl_gate || gh[1]);
            else if (ctl_sync) pulse = eh[1] && !eh[2];
            else               pulse = ext_clk && !eh[0];
            gmode = ctl_gate && !ctl_ext;
            fall  = gmode && ctl_on && gh[2] && !gh[1];
            adv   = ctl_on && !(ctl_sidl && idle) && pulse;
            lim   = (ctl_ps == 2'd0) ? 0 : (ctl_ps == 2'd1) ? 7 : (ctl_ps == 2'd2) ? 63 : 255;
            stp   = adv && (m_pre >= lim);
            hit   = stp && (m_cnt == m_per);
            if (cnt_we || !ctl_on) m_pre = 0;
            else if (adv)          m_pre = (m_pre >= lim) ? 0 : m_pre + 1;
            if (cnt_we)   m_cnt = cnt_wdata;
            else if (stp) m_cnt = hit ? 0 : (m_cnt + 1) % 65536;
            if (per_we) m_per = per_wdata;
            if ((hit && !gmode) || fall) m_flag = 1;
            else if (flag_clr)           m_flag = 0;
            eh[2] = eh[1]; eh[1] = eh[0]; eh[0] = ext_clk;
            gh[2] = gh[1]; gh[1] = gh[0]; gh[0] = ext_gate;
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    // Compare registered outputs with the model at every falling edge.
    always @(negedge clk) begin
        cycles++;
        if (comparing && rst_n) begin
            check(cnt_q == m_cnt[15:0], "cnt_q", cnt_q, m_cnt);
            check(flag_q == m_flag, "flag_q", flag_q, m_flag);
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        wait (cycles > 150000);
        check(1'b0, "watchdog", cycles, 0);
        finish_run();
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_cnt(input int v);
        @(negedge clk); cnt_we = 1'b1; cnt_wdata = 16'(v);
        @(negedge clk); cnt_we = 1'b0;
    endtask

    task automatic wr_per(input int v);
        @(negedge clk); per_we = 1'b1; per_wdata = 16'(v);
        @(negedge clk); per_we = 1'b0;
    endtask

    task automatic clr_flag();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    // External clock with a given half period in system clocks.
    task automatic run_ext(input int n, input int half);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if ((i % half) == 0) ext_clk = ~ext_clk;
        end
    endtask

    task automatic run_ticks(input int n, input int pct);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en = (($urandom % 100) < pct);
        end
    endtask

    initial begin
        cyc(3);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        check(cnt_q == 16'h0, "reset cnt", cnt_q, 0);
        check(flag_q == 1'b0, "reset flag", flag_q, 0);
        comparing = 1'b1;
        // R1: default period is all ones, so the count wraps there.
        wr_cnt(16'hFFFD);
        ctl_on = 1'b1; tick_en = 1'b1;
        cyc(6);
        clr_flag();

        // R3 / R2: timer mode, dense and sparse ticks, short period.
        cur_req = "R3";
        wr_per(5); wr_cnt(0);
        run_ticks(40, 100);
        run_ticks(60, 50);
        cur_req = "R2";
        clr_flag();
        wr_cnt(200);
        run_ticks(30, 100);
        wr_cnt(16'hFFFE);
        run_ticks(10, 100);

        // R6: each prescaler code.
        cur_req = "R6";
        ctl_ps = 2'b01; run_ticks(120, 100);
        ctl_ps = 2'b10; wr_per(2); run_ticks(500, 90);
        ctl_ps = 2'b11; run_ticks(1600, 100);

        // R7: prescaler restarts on count write and on disable.
        cur_req = "R7";
        ctl_ps = 2'b01; wr_per(100);
        run_ticks(5, 100); wr_cnt(3); run_ticks(12, 100);
        ctl_on = 1'b0; cyc(2); ctl_on = 1'b1; run_ticks(20, 100);

        // R11: clear racing a set event; clear alone.
        cur_req = "R11";
        ctl_ps = 2'b00; wr_per(4); wr_cnt(0); tick_en = 1'b1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk); flag_clr = (i % 5 == 4) || (i % 7 == 3);
        end
        flag_clr = 1'b0;

        // R13: writes while counting, period write at a match.
        cur_req = "R13";
        wr_cnt(2); wr_cnt(4);
        @(negedge clk); per_we = 1'b1; per_wdata = 16'd9; cnt_we = 1'b1; cnt_wdata = 16'd1;
        @(negedge clk); per_we = 1'b0; cnt_we = 1'b0;
        run_ticks(25, 100);

        // R4: synchronized external clock.
        cur_req = "R4";
        tick_en = 1'b0; ctl_ext = 1'b1; ctl_sync = 1'b1; wr_per(6);
        run_ext(120, 3); run_ext(60, 1);
        // R5: raw external edges.
        cur_req = "R5";
        ctl_sync = 1'b0;
        run_ext(120, 2); run_ext(60, 1);
        // R9: gate ignored with external source.
        cur_req = "R9";
        ctl_gate = 1'b1; ext_gate = 1'b0;
        run_ext(40, 2);
        ctl_gate = 1'b0; ctl_ext = 1'b0;

        // R8: stop-in-idle on and off.
        cur_req = "R8";
        wr_per(50); tick_en = 1'b1;
        ctl_sidl = 1'b1;
        for (int i = 0; i < 60; i++) begin @(negedge clk); idle = (i % 10) < 4; end
        ctl_sidl = 1'b0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); idle = (i % 6) < 3; end
        idle = 1'b0;

        // R9 / R10: gated accumulation and falling-edge flag.
        cur_req = "R9";
        clr_flag(); wr_per(3); wr_cnt(0); ctl_gate = 1'b1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (i % 9 == 0) ext_gate = ~ext_gate;
            tick_en = (i % 3) != 1;
        end
        cur_req = "R10";
        for (int i = 0; i < 6; i++) begin
            clr_flag();
            @(negedge clk); ext_gate = 1'b1; cyc(5);
            @(negedge clk); ext_gate = 1'b0; cyc(5);
        end
        ctl_on = 1'b0; ext_gate = 1'b1; cyc(4); clr_flag();
        ext_gate = 1'b0; cyc(5);
        ctl_on = 1'b1; ctl_gate = 1'b0;

        // R12: disabled timer freezes.
        cur_req = "R12";
        wr_cnt(11); ctl_on = 1'b0; run_ticks(30, 100);
        ctl_on = 1'b1; run_ticks(10, 100);

        cyc(2);
        finish_run();
    end
endmodule